// File: doc/BRIEF.md
# Programmable Bit-Clock and Frame-Sync Generator

This block derives a slower serial bit clock from a fast source clock and builds a repeating frame-sync pulse on top of it. The same bit clock can drive the conversion clock of an external sampling converter and the local serial receiver. Both therefore see one common timebase and one common frame boundary. Every rising edge of the bit clock falls on a rising edge of the source clock. A one-cycle strobe marks those edges, so logic in the source domain can act on bit-clock edges without a second clock.

Software-visible settings arrive as plain inputs:
- a divide value N
- a frame period P
- a pulse width W
- a polarity select for the clock copy driven to the pin
- an enable

After the enable rises, or after the divide value changes while enabled, the generator holds its outputs quiet through a two-cycle settling wait and then starts the clock high. Clearing the enable stops everything at once.

Top module: `bitclk_fs_gen`

## Requirements
- R1: While reset is high and on the first edges after it, `bclk`, `bclk_stb` and `fsync` are 0 and `bclk_pin` equals `pin_rise_sel`.
- R2: With divide value N the bit clock repeats every N+1 source cycles and is high for the first (N+2)/2 (integer division) of them.
- R3: When `en` rises, `bclk` stays low at the first two source edges that sample `en` high and goes high at the third.
- R4: `bclk_stb` is high for exactly one source cycle per bit-clock period, namely the cycle in which `bclk` has just gone high.
- R5: `fsync` goes high together with the first bit-clock high phase after start, and from then on repeats every P+1 bit-clock periods, rising only in a strobe cycle.
- R6: Each frame pulse lasts W+1 bit-clock periods; when W is at least P, `fsync` stays high continuously.
- R7: `bclk_pin` equals `bclk` when `pin_rise_sel` is 0 and its inverse when it is 1, the select taking effect one source cycle later.
- R8: At the first source edge that samples `en` low, `bclk`, `bclk_stb` and `fsync` go to 0; a later enable again waits as in R3.
- R9: When `div_val` changes while enabled, the edge that samples the new value forces the outputs low. `bclk` then goes high again at the fourth source edge, counting that one, and runs with the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| div_val | input | DIV_W | Divide value N, period N+1 source cycles |
| frm_period | input | FP_W | Frame period P, frame every P+1 bit clocks |
| frm_width | input | FW_W | Pulse width W, pulse W+1 bit clocks long |
| pin_rise_sel | input | 1 | 1 inverts the pin copy of the bit clock |
| bclk | output | 1 | Divided bit clock, internal polarity |
| bclk_stb | output | 1 | One-cycle strobe on each bit-clock rising edge |
| fsync | output | 1 | Frame-sync pulse |
| bclk_pin | output | 1 | Bit clock after the polarity option |

## Verification
The assertions assume that `div_val` is not changed merely to restart the clock: a change is taken as reprogramming. They also assume that `frm_period` and `frm_width` are held steady while a frame is under measurement, since those two act live without a restart. The stimulus applies each configuration only while the enable is low and lets several cycles pass before enabling. The only mid-run change it makes is the deliberate divide-value change that exercises the restart.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  // Source cycles the generator waits after enable or reprogramming.
  localparam int SETTLE_CYCLES = 2;
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  typedef logic [SETTLE_W-1:0] settle_cnt_t;
endpackage

// File: rtl/bfg_settle.sv
module bfg_settle #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             start,
  output logic             keep
);
  import bfg_pkg::*;

  logic [DIV_W-1:0] div_q;
  settle_cnt_t      cnt;
  logic             run;
  logic             chg;

  assign chg   = (div_val != div_q);
  assign start = en && !chg && !run && (cnt == settle_cnt_t'(SETTLE_CYCLES));
  assign keep  = en && !chg && run;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
    end else begin
      div_q <= div_val;
      if (!en || chg) begin
        cnt <= '0;
        run <= 1'b0;
      end else if (start) begin
        run <= 1'b1;
      end else if (!run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfg_div.sv
module bfg_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             keep,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk,
  output logic             stb,
  output logic             wrap,
  output logic             bclk_nxt
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] ph;
  logic [DIV_W-1:0] ph_nxt;
  logic [HW-1:0]    hi;
  logic             active;

  assign active = start || keep;
  assign hi     = (HW'(div_val) + HW'(2)) >> 1;

  always_comb begin
    if (start || ph == div_val) ph_nxt = '0;
    else                        ph_nxt = ph + 1'b1;
  end

  assign wrap     = active && (ph_nxt == '0);
  assign bclk_nxt = active && (HW'(ph_nxt) < hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      bclk <= 1'b0;
      stb  <= 1'b0;
    end else begin
      ph   <= active ? ph_nxt : '0;
      bclk <= bclk_nxt;
      stb  <= wrap;
    end
  end
endmodule

// File: rtl/bfg_frame.sv
module bfg_frame #(
  parameter int FP_W = 8,
  parameter int FW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            keep,
  input  logic            wrap,
  input  logic [FP_W-1:0] frm_period,
  input  logic [FW_W-1:0] frm_width,
  output logic            fsync
);
  localparam int MW = (FP_W > FW_W) ? FP_W : FW_W;

  logic [FP_W-1:0] fc;
  logic [FP_W-1:0] fc_adv;
  logic            in_pulse;

  assign fc_adv   = (fc >= frm_period) ? '0 : fc + 1'b1;
  assign in_pulse = MW'(fc_adv) <= MW'(frm_width);

  always_ff @(posedge clk) begin
    if (rst) begin
      fc    <= '0;
      fsync <= 1'b0;
    end else if (start) begin
      fc    <= '0;
      fsync <= 1'b1;
    end else if (keep) begin
      if (wrap) begin
        fc    <= fc_adv;
        fsync <= in_pulse;
      end
    end else begin
      fc    <= '0;
      fsync <= 1'b0;
    end
  end
endmodule

// File: rtl/bitclk_fs_gen.sv
module bitclk_fs_gen #(
  parameter int DIV_W = 8,
  parameter int FP_W  = 8,
  parameter int FW_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [FP_W-1:0]  frm_period,
  input  logic [FW_W-1:0]  frm_width,
  input  logic             pin_rise_sel,
  output logic             bclk,
  output logic             bclk_stb,
  output logic             fsync,
  output logic             bclk_pin
);
  logic start, keep, wrap, bclk_nxt;

  bfg_settle #(.DIV_W(DIV_W)) u_settle (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val),
    .start(start), .keep(keep)
  );

  bfg_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .keep(keep), .div_val(div_val),
    .bclk(bclk), .stb(bclk_stb), .wrap(wrap), .bclk_nxt(bclk_nxt)
  );

  bfg_frame #(.FP_W(FP_W), .FW_W(FW_W)) u_frame (
    .clk(clk), .rst(rst), .start(start), .keep(keep), .wrap(wrap),
    .frm_period(frm_period), .frm_width(frm_width), .fsync(fsync)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_pin <= pin_rise_sel;
    else     bclk_pin <= bclk_nxt ^ pin_rise_sel;
  end
endmodule

// File: rtl/bitclk_fs_gen_chk.sv
module bitclk_fs_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic pin_rise_sel,
  input logic bclk,
  input logic bclk_stb,
  input logic fsync,
  input logic bclk_pin
);
  p_settle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> !bclk ##1 !bclk);

  p_stb_high_r4: assert property (@(posedge clk) disable iff (rst)
    bclk_stb |-> bclk);

  p_rise_stb_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |-> bclk_stb);

  p_fs_on_stb_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> bclk_stb);

  p_pin_pol_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bclk_pin == (bclk ^ $past(pin_rise_sel))));

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bclk && !fsync && !bclk_stb));
endmodule

bind bitclk_fs_gen bitclk_fs_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .pin_rise_sel(pin_rise_sel),
  .bclk(bclk), .bclk_stb(bclk_stb), .fsync(fsync), .bclk_pin(bclk_pin)
);

// File: tb/bitclk_fs_gen_test.sv
module bitclk_fs_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed { int n; int p; int w; int pol; } vec_t;
  localparam vec_t VECS [NV] = '{
    '{0, 3, 1, 0}, '{1, 3, 0, 0}, '{2, 4, 1, 1}, '{3, 2, 0, 0},
    '{4, 5, 2, 1}, '{5, 7, 3, 0}, '{1, 2, 5, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [7:0] div_val = '0;
  logic [7:0] frm_period = '0;
  logic [7:0] frm_width = '0;
  logic pol = 1'b0;
  logic bclk, bclk_stb, fsync, bclk_pin;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bitclk_fs_gen uut (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val),
    .frm_period(frm_period), .frm_width(frm_width), .pin_rise_sel(pol),
    .bclk(bclk), .bclk_stb(bclk_stb), .fsync(fsync), .bclk_pin(bclk_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int n, input int p, input int w, input int pl);
    @(negedge clk);
    en = 1'b0;
    div_val = 8'(n); frm_period = 8'(p); frm_width = 8'(w); pol = pl[0];
    repeat (3) @(negedge clk);
  endtask

  // Enables, then returns index of first bclk high (edges counted from enable).
  task automatic first_rise(output int idx);
    idx = -1;
    en = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (bclk && idx < 0) idx = i;
      if (idx >= 0) break;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int f, hi_exp, first, hi_cnt, stb_cnt, fs_cnt, pin_bad, fs_exp;
    f = (v.p + 1) * (v.n + 1);
    hi_exp = (v.n + 2) / 2;
    fs_exp = ((v.w < v.p) ? v.w + 1 : v.p + 1) * (v.n + 1);
    first = -1; hi_cnt = 0; stb_cnt = 0; fs_cnt = 0; pin_bad = 0;
    configure(v.n, v.p, v.w, v.pol);
    en = 1'b1;
    for (int i = 1; i <= 3 + f; i++) begin
      @(negedge clk);
      if (bclk && first < 0) first = i;
      if (i >= 3 && i <= 3 + v.n && bclk) hi_cnt++;
      if (i >= 3 && i < 3 + f) begin
        if (bclk_stb) stb_cnt++;
        if (fsync) fs_cnt++;
      end
      if (i == 3) chk(fsync == 1'b1, "R5 fsync at start", int'(fsync), 1);
      if (i == 3 + f) chk(fsync && bclk_stb, "R5 fsync repeat", int'(fsync), 1);
      if (bclk_pin != (bclk ^ pol)) pin_bad++;
    end
    chk(first == 3, "R3 first rise", first, 3);
    chk(hi_cnt == hi_exp, "R2 high phase", hi_cnt, hi_exp);
    chk(stb_cnt == v.p + 1, "R4 strobe count", stb_cnt, v.p + 1);
    chk(fs_cnt == fs_exp, "R6 pulse length", fs_cnt, fs_exp);
    chk(pin_bad == 0, "R7 pin polarity", pin_bad, 0);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    int idx;
    pol = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bclk == 1'b0, "R1 bclk reset", int'(bclk), 0);
    chk(fsync == 1'b0, "R1 fsync reset", int'(fsync), 0);
    chk(bclk_stb == 1'b0, "R1 stb reset", int'(bclk_stb), 0);
    chk(bclk_pin == 1'b1, "R1 pin reset", int'(bclk_pin), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(bclk_pin == 1'b1 && bclk == 1'b0, "R1 idle after reset", int'(bclk_pin), 1);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: disable mid-run, then re-enable.
    configure(3, 2, 0, 0);
    first_rise(idx);
    chk(idx == 3, "R8 pre-disable rise", idx, 3);
    en = 1'b0;
    @(negedge clk);
    chk(!bclk && !fsync && !bclk_stb, "R8 stop", int'({bclk, fsync, bclk_stb}), 0);
    first_rise(idx);
    chk(idx == 3, "R8 re-enable wait", idx, 3);

    // R9: change divide value while running.
    repeat (2) @(negedge clk);
    div_val = 8'd1;
    idx = -1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) chk(bclk == 1'b0, "R9 forced low", int'(bclk), 0);
      if (bclk && idx < 0) idx = i;
      if (i == 5) chk(bclk == 1'b0, "R9 new period low", int'(bclk), 0);
      if (i == 6) chk(bclk == 1'b1, "R9 new period high", int'(bclk), 1);
    end
    chk(idx == 4, "R9 restart edge", idx, 4);
    en = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule